// File: doc/BRIEF.md
# Sub-word Load/Store Data Aligner

This block sits between a 32-bit register file and a byte-addressed, little-endian 32-bit data memory port. It handles byte, halfword and word accesses. On a store, it takes the source register, places its low byte or low halfword on every lane where that unit could land, and drives a per-byte write-enable mask so that only the addressed lanes are written. On a load, it remembers the low address bits, the access size and the signedness of the request. When the memory word returns one cycle later, it picks out the addressed byte or halfword and widens it to 32 bits, copying the sign bit or filling with zeros.

Signed and unsigned loads share one selection and extension path. A single fill bit is the only thing that differs between them. A halfword request with address bit 0 set, or a word request with either low address bit set, raises a misalign flag and suppresses every write enable. Address generation and exception handling are left to the surrounding pipeline.

Top module: `subword_aligner`

## Requirements
- R1: For a signed byte load (size code 0, `req_zext`=0), `ld_data` equals the byte at lane `addr[1:0]` of `mem_rdata` (lane n is bits 8n+7..8n), with bit 7 of that byte copied into bits 31..8.
- R2: For a signed halfword load (size code 1, `req_zext`=0), `ld_data` equals `mem_rdata[15:0]` when `addr[1]`=0 or `mem_rdata[31:16]` when `addr[1]`=1, with bit 15 of that halfword copied into bits 31..16.
- R3: For an unsigned byte or halfword load (`req_zext`=1), `ld_data` holds the same selected byte or halfword as in R1/R2, with every bit above it zero.
- R4: For a word load (size code 2, and also code 3), `ld_data` equals `mem_rdata` unchanged.
- R5: The load context (address bits, size, signedness) is captured at a clock edge only when `req_valid`=1 and `req_store`=0. `ld_data` is combinational from `mem_rdata` and that context. After reset the context reads as an unsigned word at lane 0, so `ld_data` equals `mem_rdata`.
- R6: For an aligned byte store, `mem_wdata` carries `st_data[7:0]` on all four lanes, and `mem_be` has exactly the single bit for lane `addr[1:0]` set.
- R7: For an aligned halfword store, `mem_wdata` carries `st_data[15:0]` in both halves, and `mem_be` is 4'b0011 when `addr[1]`=0 or 4'b1100 when `addr[1]`=1.
- R8: For an aligned word store, `mem_wdata` equals `st_data` and `mem_be` is 4'b1111.
- R9: While `req_valid`=1, `misalign` is 1 exactly for a halfword request with `addr[0]`=1 or a word request with `addr[1:0]`≠0, whether load or store. While it is 1, `mem_be` is 4'b0000.
- R10: `mem_be` is 4'b0000 whenever `req_valid`=0 or `req_store`=0, and `misalign` is 0 whenever `req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = treated as word |
| req_zext | input | 1 | Load fill: 1 = zero-extend, 0 = sign-extend |
| req_addr | input | 2 | Low byte-address bits of the access |
| st_data | input | 32 | Store source register value |
| mem_wdata | output | 32 | Lane-replicated store data to memory |
| mem_be | output | 4 | Per-byte write enables, bit n for lane n |
| misalign | output | 1 | Request address not aligned to its size |
| mem_rdata | input | 32 | Word returned by memory for the previous load |
| ld_data | output | 32 | Extended load result for the register file |

## Verification
Assertions run on every cycle and check the structure of the outputs. They confirm that a misaligned or absent store never enables a lane, that a byte store enables exactly one lane and a halfword store an adjacent pair, that the bits above a signed sub-word result all copy its top bit, that the bits above an unsigned one are zero, that word loads pass through, and that the load context holds still across stores and idle cycles. Only the bench's scenarios can show that the correct lane and correct data were picked. They walk every lane, drive data with the sign bit both set and clear, and show that a store placed between a load request and its returned word leaves the selection untouched.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2,
      ACC_RSVD = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic [1:0] lane;
      acc_size_e  size;
      logic       zext;
   } ld_ctx_t;

   localparam ld_ctx_t LD_CTX_RESET = '{lane: 2'd0, size: ACC_WORD, zext: 1'b1};

   // Alignment rule: halfword needs bit 0 clear, word needs both clear.
   function automatic logic is_misaligned(input acc_size_e sz, input logic [1:0] lane);
      logic bad;
      unique case (sz)
         ACC_BYTE: bad = 1'b0;
         ACC_HALF: bad = lane[0];
         default:  bad = |lane;
      endcase
      return bad;
   endfunction

endpackage

// File: rtl/aligner_ctx_reg.sv
module aligner_ctx_reg
   import aligner_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cap_i,
   input  ld_ctx_t ctx_i,
   output ld_ctx_t ctx_o
);

   ld_ctx_t ctx_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctx_q <= LD_CTX_RESET;
      else if (cap_i)
         ctx_q <= ctx_i;
   end

   assign ctx_o = ctx_q;

   AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(ctx_o)) else $error("load context moved without a load request"); // R5

   AST_CTX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (ctx_o == $past(ctx_i))) else $error("load context not captured"); // R5

endmodule

// File: rtl/aligner_store_lanes.sv
module aligner_store_lanes
   import aligner_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int LANE_W = $clog2(LANES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              mis_i,
   input  acc_size_e         size_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] wdata_o,
   output logic [LANES-1:0]  be_o
);

   localparam int HALF_LANES = 2;

   logic [LANES-1:0] be_raw;
   logic             wr_ok;

   assign wr_ok = wr_i & ~mis_i;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
         unique case (size_i)
            ACC_BYTE: begin
               wdata_o[i*8 +: 8] = src_i[7:0];
               be_raw[i]         = (lane_i == LANE_W'(i));
            end
            ACC_HALF: begin
               wdata_o[i*8 +: 8] = src_i[(i % HALF_LANES)*8 +: 8];
               be_raw[i]         = (lane_i[LANE_W-1] == 1'(i / HALF_LANES));
            end
            default: begin
               wdata_o[i*8 +: 8] = src_i[i*8 +: 8];
               be_raw[i]         = 1'b1;
            end
         endcase
      end
   end

   assign be_o = wr_ok ? be_raw : '0;

   AST_BE_MISALIGN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      mis_i |-> (be_o == '0)) else $error("write enabled on misaligned access"); // R9

   AST_BE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |-> (be_o == '0)) else $error("write enabled with no store"); // R10

   AST_BE_BYTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && size_i == ACC_BYTE) |-> ($countones(be_o) == 1)) else $error("byte store lane count"); // R6

   AST_BE_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && size_i == ACC_HALF) |-> (be_o == 4'b0011 || be_o == 4'b1100)) else $error("halfword store lanes"); // R7

   AST_BE_WORD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && (size_i == ACC_WORD || size_i == ACC_RSVD)) |-> (&be_o)) else $error("word store lanes"); // R8

endmodule

// File: rtl/aligner_load_extract.sv
module aligner_load_extract
   import aligner_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int LANE_W = $clog2(LANES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  ld_ctx_t           ctx_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] result_o
);

   localparam int HW = 16;

   logic [7:0]    lane_bytes [LANES];
   logic [7:0]    byte_sel;
   logic [HW-1:0] half_sel;
   logic          fill_b;
   logic          fill_h;

   for (genvar i = 0; i < LANES; i++) begin : g_split
      assign lane_bytes[i] = rdata_i[i*8 +: 8];
   end

   assign byte_sel = lane_bytes[ctx_i.lane[LANE_W-1:0]];
   assign half_sel = ctx_i.lane[LANE_W-1] ? rdata_i[DATA_W-1 -: HW] : rdata_i[HW-1:0];

   // One fill bit per width; zext forces it low, so both variants share the mux.
   assign fill_b = ~ctx_i.zext & byte_sel[7];
   assign fill_h = ~ctx_i.zext & half_sel[HW-1];

   always_comb begin
      unique case (ctx_i.size)
         ACC_BYTE: result_o = {{(DATA_W-8){fill_b}}, byte_sel};
         ACC_HALF: result_o = {{(DATA_W-HW){fill_h}}, half_sel};
         default:  result_o = rdata_i;
      endcase
   end

   AST_SEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_i.size == ACC_BYTE && !ctx_i.zext) |-> (result_o[DATA_W-1:8] == {(DATA_W-8){result_o[7]}}))
      else $error("signed byte not sign-extended"); // R1

   AST_SEXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_i.size == ACC_HALF && !ctx_i.zext) |-> (result_o[DATA_W-1:HW] == {(DATA_W-HW){result_o[HW-1]}}))
      else $error("signed halfword not sign-extended"); // R2

   AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_i.size == ACC_BYTE && ctx_i.zext) |-> (result_o[DATA_W-1:8] == '0))
      else $error("unsigned byte upper bits"); // R3

   AST_ZEXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_i.size == ACC_HALF && ctx_i.zext) |-> (result_o[DATA_W-1:HW] == '0))
      else $error("unsigned halfword upper bits"); // R3

   AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_i.size == ACC_WORD || ctx_i.size == ACC_RSVD) |-> (result_o == rdata_i))
      else $error("word load altered"); // R4

endmodule

// File: rtl/subword_aligner.sv
module subword_aligner
   import aligner_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int LANE_W = $clog2(LANES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [1:0]        req_size,
   input  logic              req_zext,
   input  logic [LANE_W-1:0] req_addr,
   input  logic [DATA_W-1:0] st_data,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [LANES-1:0]  mem_be,
   output logic              misalign,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] ld_data
);

   if (DATA_W != 32) begin : g_bad_width
      $error("subword_aligner supports a 32-bit data path only");
   end
   if (LANES * 8 != DATA_W || LANE_W != 2) begin : g_bad_lanes
      $error("subword_aligner lane parameters inconsistent with DATA_W");
   end

   acc_size_e size_e;
   ld_ctx_t   ctx_in;
   ld_ctx_t   ctx_cur;
   logic      ld_cap;
   logic      st_wr;

   assign size_e   = acc_size_e'(req_size);
   assign misalign = req_valid & is_misaligned(size_e, req_addr);
   assign ld_cap   = req_valid & ~req_store;
   assign st_wr    = req_valid & req_store;

   assign ctx_in.lane = req_addr;
   assign ctx_in.size = size_e;
   assign ctx_in.zext = req_zext;

   aligner_ctx_reg u_ctx (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_i (ld_cap),
      .ctx_i (ctx_in),
      .ctx_o (ctx_cur)
   );

   aligner_store_lanes #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (st_wr),
      .mis_i   (misalign),
      .size_i  (size_e),
      .lane_i  (req_addr),
      .src_i   (st_data),
      .wdata_o (mem_wdata),
      .be_o    (mem_be)
   );

   aligner_load_extract #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctx_i    (ctx_cur),
      .rdata_i  (mem_rdata),
      .result_o (ld_data)
   );

   AST_MIS_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !misalign) else $error("misalign raised without request"); // R10

   AST_MIS_BYTE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_size == 2'd0) |-> !misalign) else $error("byte access flagged misaligned"); // R9

endmodule

// File: tb/sim_subword_aligner.sv
module sim_subword_aligner;

   logic        clk;
   logic        rst_n;
   logic        req_valid;
   logic        req_store;
   logic [1:0]  req_size;
   logic        req_zext;
   logic [1:0]  req_addr;
   logic [31:0] st_data;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_be;
   logic        misalign;
   logic [31:0] mem_rdata;
   logic [31:0] ld_data;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   subword_aligner u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_store (req_store),
      .req_size  (req_size),
      .req_zext  (req_zext),
      .req_addr  (req_addr),
      .st_data   (st_data),
      .mem_wdata (mem_wdata),
      .mem_be    (mem_be),
      .misalign  (misalign),
      .mem_rdata (mem_rdata),
      .ld_data   (ld_data)
   );

   initial clk = 0;
   always #10 clk = ~clk;   // 50 MHz

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] model_load(input logic [31:0] rd, input logic [1:0] sz,
                                              input logic zx, input logic [1:0] a);
      logic [7:0]  b;
      logic [15:0] h;
      b = rd[a*8 +: 8];
      h = a[1] ? rd[31:16] : rd[15:0];
      if (sz == 2'd0) return zx ? {24'h0, b} : {{24{b[7]}}, b};
      if (sz == 2'd1) return zx ? {16'h0, h} : {{16{h[15]}}, h};
      return rd;
   endfunction

   task automatic idle();
      req_valid = 0; req_store = 0; req_size = 0; req_zext = 0; req_addr = 0; st_data = 0;
   endtask

   // Issue a load request, then return the memory word in the next cycle.
   task automatic do_load(input string req, input logic [1:0] sz, input logic zx,
                          input logic [1:0] a, input logic [31:0] rd);
      @(negedge clk);
      req_valid = 1; req_store = 0; req_size = sz; req_zext = zx; req_addr = a;
      @(negedge clk);
      idle();
      mem_rdata = rd;
      #1;
      chk(req, ld_data, model_load(rd, sz, zx, a));
   endtask

   task automatic do_store(input string req, input logic [1:0] sz, input logic [1:0] a,
                           input logic [31:0] src, input logic [31:0] exp_wd, input logic [3:0] exp_be);
      @(negedge clk);
      req_valid = 1; req_store = 1; req_size = sz; req_zext = 0; req_addr = a; st_data = src;
      #1;
      chk({req, " be"}, {28'h0, mem_be}, {28'h0, exp_be});
      if (exp_be != 4'h0) chk({req, " wdata"}, mem_wdata, exp_wd);
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      rst_n = 0; idle(); mem_rdata = 32'hC3A5_5A3C;
      repeat (3) @(negedge clk);
      #1;
      chk("R5 reset ld_data", ld_data, 32'hC3A5_5A3C);
      chk("R10 reset be", {28'h0, mem_be}, 32'h0);
      chk("R10 reset misalign", {31'h0, misalign}, 32'h0);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic t_signed_byte();
      for (int a = 0; a < 4; a++) begin
         do_load("R1 signed byte neg", 2'd0, 1'b0, 2'(a), 32'h8090_A0F1);
         do_load("R1 signed byte pos", 2'd0, 1'b0, 2'(a), 32'h7F12_3456);
      end
   endtask

   task automatic t_signed_half();
      do_load("R2 signed half lo neg", 2'd1, 1'b0, 2'd0, 32'h1234_8001);
      do_load("R2 signed half hi neg", 2'd1, 1'b0, 2'd2, 32'hFEDC_0123);
      do_load("R2 signed half hi pos", 2'd1, 1'b0, 2'd2, 32'h7FFF_8000);
   endtask

   task automatic t_unsigned();
      for (int a = 0; a < 4; a++)
         do_load("R3 unsigned byte", 2'd0, 1'b1, 2'(a), 32'h8899_AABB);
      do_load("R3 unsigned half lo", 2'd1, 1'b1, 2'd0, 32'h0000_F00D);
      do_load("R3 unsigned half hi", 2'd1, 1'b1, 2'd2, 32'hBEEF_0000);
   endtask

   task automatic t_word();
      do_load("R4 word load", 2'd2, 1'b0, 2'd0, 32'hDEAD_BEEF);
      do_load("R4 size3 as word", 2'd3, 1'b0, 2'd0, 32'h8000_0001);
   endtask

   task automatic t_ctx_hold();
      // Load byte lane 3 signed, then a store and idle cycles before the word returns.
      @(negedge clk);
      req_valid = 1; req_store = 0; req_size = 0; req_zext = 0; req_addr = 2'd3;
      @(negedge clk);
      req_valid = 1; req_store = 1; req_size = 2; req_zext = 1; req_addr = 2'd0; st_data = 32'h1;
      @(negedge clk);
      idle();
      @(negedge clk);
      mem_rdata = 32'h9A00_0000;
      #1;
      chk("R5 ctx held across store", ld_data, 32'hFFFF_FF9A);
   endtask

   task automatic t_store_byte();
      for (int a = 0; a < 4; a++)
         do_store("R6 byte store", 2'd0, 2'(a), 32'h1234_56C7, 32'hC7C7_C7C7, 4'(1 << a));
   endtask

   task automatic t_store_half();
      do_store("R7 half store lo", 2'd1, 2'd0, 32'hAAAA_5B6C, 32'h5B6C_5B6C, 4'b0011);
      do_store("R7 half store hi", 2'd1, 2'd2, 32'hAAAA_5B6C, 32'h5B6C_5B6C, 4'b1100);
   endtask

   task automatic t_store_word();
      do_store("R8 word store", 2'd2, 2'd0, 32'h0BAD_F00D, 32'h0BAD_F00D, 4'b1111);
   endtask

   task automatic t_misalign();
      do_store("R9 half store odd", 2'd1, 2'd1, 32'h1111_2222, 32'h0, 4'b0000);
      do_store("R9 half store lane3", 2'd1, 2'd3, 32'h1111_2222, 32'h0, 4'b0000);
      do_store("R9 word store off2", 2'd2, 2'd2, 32'h1111_2222, 32'h0, 4'b0000);
      for (int a = 0; a < 4; a++)
         for (int s = 0; s < 3; s++) begin
            logic exp_m;
            exp_m = (s == 1) ? a[0] : ((s == 2) ? (a != 0) : 1'b0);
            @(negedge clk);
            req_valid = 1; req_store = 0; req_size = 2'(s); req_addr = 2'(a);
            #1;
            chk("R9 misalign flag load", {31'h0, misalign}, {31'h0, exp_m});
         end
      @(negedge clk);
      idle();
   endtask

   task automatic t_idle();
      @(negedge clk);
      idle(); req_size = 2'd1; req_addr = 2'd1; req_store = 1; st_data = 32'hFFFF_FFFF;
      #1;
      chk("R10 idle be", {28'h0, mem_be}, 32'h0);
      chk("R10 idle misalign", {31'h0, misalign}, 32'h0);
      @(negedge clk);
      req_valid = 1; req_store = 0; req_size = 2'd0; req_addr = 2'd2;
      #1;
      chk("R10 load no be", {28'h0, mem_be}, 32'h0);
      @(negedge clk);
      idle();
   endtask

   initial begin
      t_reset();
      t_signed_byte();
      t_signed_half();
      t_unsigned();
      t_word();
      t_ctx_hold();
      t_store_byte();
      t_store_half();
      t_store_word();
      t_misalign();
      t_idle();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule